// File: doc/BRIEF.md
# Oversampled Serial Time-Bus Receiver

This block sits on every capture card that listens to a shared serial time bus. The bus line is NRZ-coded and is not related to the card's own clock. The receiver samples the line four times per bit and turns the samples back into bits. It finds frames by a long run of ones, checks each frame with an 8-bit CRC and then sorts good frames into two kinds: time frames and data frames. Frames of the two kinds take turns on the bus, so a new time value arrives at regular intervals.

A good time frame sets the local time counter. The counter advances by one on every clock. The receiver adds a fixed compensation to the received value to cover the constant delay of the line and of its own pipeline. The counter never runs backwards. If the compensated value is behind the local count, the counter stops and waits until the reference time reaches it. A good data frame produces a one-cycle strobe that carries its payload. The receiver also keeps a lock flag and two saturating error counters: one for frames that fail the CRC and one for frames that never arrived.

Top module: `tsr_rx`

## Requirements
- R1: The line passes through two synchroniser flops. A phase counter restarts on every change of the line level. The bit value is taken from the third of its four samples, so bits are recovered correctly when individual bit cells are stretched or shrunk by one sample.
- R2: A frame starts after at least 32 consecutive one bits followed by a zero. Then come, MSB first: one kind bit (1 = time, 0 = data), a 32-bit payload and an 8-bit CRC. A run of fewer than 32 ones starts no frame.
- R3: The CRC uses the polynomial x^8+x^2+x+1 with an initial value of zero. It is computed MSB first over the kind bit and the payload. A frame whose received CRC does not match is discarded.
- R4: A good data frame raises `data_vld` for exactly one cycle with `data_out` equal to its payload. It does not change the local time.
- R5: For a good time frame, let target = payload + LAT_COMP (default 24). If target is greater than the current local time, `local_time` equals target in the cycle where `time_upd` is high.
- R6: If target is not greater than the local time, `local_time` keeps its value. It stays there until a reference started at target, advancing one per cycle, reaches it. From then on it follows that reference. `local_time` never decreases.
- R7: Without an update or a pending hold, `local_time` increases by exactly one each cycle.
- R8: A frame that fails the CRC increments `crc_err_cnt`, which saturates. It raises neither `time_upd` nor `data_vld`.
- R9: `locked` rises when the second good time frame in a row is received, with no bad or missing frame between the two.
- R10: A miss is either a bad frame or a span of GAP_LIMIT cycles (default 1024) with no frame end. A timeout miss also increments `miss_cnt`. `locked` falls once LOSS_LIMIT misses (default 3) have occurred in a row. Any good frame restarts that run.
- R11: After reset, `local_time` is 0, `locked` is 0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, four times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Asynchronous serial time-bus line |
| local_time | output | 32 | Corrected local time count |
| time_upd | output | 1 | One-cycle pulse when a good time frame is applied |
| data_vld | output | 1 | One-cycle pulse for a good data frame |
| data_out | output | 32 | Payload of the last good data frame |
| locked | output | 1 | Time lock indication |
| crc_err_cnt | output | 8 | Saturating count of CRC failures |
| miss_cnt | output | 8 | Saturating count of frame timeouts |

## Verification
The bench sends one time frame that lies behind local time.
- A design that stepped backwards would show a value lower than the previous sample.
- A design that froze for the wrong number of cycles would not line up with the reference it recomputes each cycle.

Bit cells alternately stretched and shortened by one sample test the phase re-centring. A receiver with a fixed phase would drop or repeat bits, and those frames would then fail the CRC or carry the wrong payload.

Corrupted frames, a sync run one bit short, and a long idle line test the discard path and the lock hysteresis. A design with any of these wrong would emit a stray strobe, keep its lock too long, or count misses wrongly.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    typedef enum logic {
        KIND_DATA = 1'b0,
        KIND_TIME = 1'b1
    } frame_kind_e;

    localparam logic [7:0] CRC_POLY = 8'h07;

    // one MSB-first step of the frame check sequence
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
        logic fb;
        fb = c[7] ^ b;
        return {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    endfunction

endpackage

// File: rtl/tsr_bit_recover.sv
module tsr_bit_recover #(
    parameter int unsigned OVS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic bit_vld,
    output logic bit_val
);
    localparam int unsigned PH_W = $clog2(OVS);
    localparam logic [PH_W-1:0] MID  = PH_W'(OVS / 2);
    localparam logic [PH_W-1:0] LAST = PH_W'(OVS - 1);

    typedef struct packed {
        logic            s1;
        logic            s2;
        logic            s3;
        logic [PH_W-1:0] ph;
        logic            vld;
        logic            val;
    } br_t;

    br_t q, d;
    logic edge_seen;

    always_comb begin
        d = q;
        d.s1 = line_in;
        d.s2 = q.s1;
        d.s3 = q.s2;
        edge_seen = q.s2 ^ q.s3;
        if (edge_seen) begin
            d.ph = PH_W'(1);
        end else if (q.ph == LAST) begin
            d.ph = '0;
        end else begin
            d.ph = q.ph + PH_W'(1);
        end
        d.vld = (q.ph == MID) && !edge_seen;
        d.val = q.s2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bit_vld = q.vld;
    assign bit_val = q.val;

    AST_BIT_SPACING: assert property (@(posedge clk) disable iff (rst)
        bit_vld |=> !bit_vld); // R1

endmodule

// File: rtl/tsr_framer.sv
module tsr_framer
    import tsr_pkg::*;
#(
    parameter int unsigned SYNC_W = 32,
    parameter int unsigned PAY_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_vld,
    input  logic             bit_val,
    output logic             frm_done,
    output logic             frm_ok,
    output logic             frm_kind,
    output logic [PAY_W-1:0] frm_pay
);
    localparam int unsigned FRAME_BITS = 1 + PAY_W + 8;
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int unsigned ONES_W     = $clog2(SYNC_W + 1);
    localparam logic [CNT_W-1:0]  CRC_END = CNT_W'(1 + PAY_W);
    localparam logic [CNT_W-1:0]  LAST    = CNT_W'(FRAME_BITS - 1);
    localparam logic [ONES_W-1:0] ONES_MX = ONES_W'(SYNC_W);

    typedef enum logic { ST_HUNT, ST_BODY } fr_state_e;

    typedef struct packed {
        fr_state_e             st;
        logic [ONES_W-1:0]     ones;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-2:0] sh;
        logic [7:0]            crc;
        logic                  done;
        logic                  ok;
        logic                  kind;
        logic [PAY_W-1:0]      pay;
    } fr_t;

    fr_t q, d;

    always_comb begin
        d = q;
        d.done = 1'b0;
        if (bit_vld) begin
            if (q.st == ST_HUNT) begin
                if (bit_val) begin
                    if (q.ones != ONES_MX) d.ones = q.ones + ONES_W'(1);
                end else begin
                    if (q.ones == ONES_MX) begin
                        d.st  = ST_BODY;
                        d.cnt = '0;
                        d.crc = '0;
                    end
                    d.ones = '0;
                end
            end else begin
                d.sh  = {q.sh[FRAME_BITS-3:0], bit_val};
                d.cnt = q.cnt + CNT_W'(1);
                if (q.cnt < CRC_END) d.crc = crc8_step(q.crc, bit_val);
                if (q.cnt == LAST) begin
                    d.done = 1'b1;
                    d.ok   = (q.crc == {q.sh[6:0], bit_val});
                    d.kind = q.sh[FRAME_BITS-2];
                    d.pay  = q.sh[PAY_W+6:7];
                    d.st   = ST_HUNT;
                    d.ones = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign frm_done = q.done;
    assign frm_ok   = q.ok;
    assign frm_kind = q.kind;
    assign frm_pay  = q.pay;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        frm_done |=> !frm_done); // R2
    AST_DONE_FROM_BODY: assert property (@(posedge clk) disable iff (rst)
        frm_done |-> $past(q.st == ST_BODY)); // R2

endmodule

// File: rtl/tsr_time_keeper.sv
module tsr_time_keeper
    import tsr_pkg::*;
#(
    parameter int unsigned TIME_W     = 32,
    parameter int unsigned LAT_COMP   = 24,
    parameter int unsigned GAP_LIMIT  = 1024,
    parameter int unsigned LOSS_LIMIT = 3,
    parameter int unsigned ERR_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_done,
    input  logic              frm_ok,
    input  logic              frm_kind,
    input  logic [TIME_W-1:0] frm_pay,
    output logic [TIME_W-1:0] local_time,
    output logic              time_upd,
    output logic              data_vld,
    output logic [TIME_W-1:0] data_out,
    output logic              locked,
    output logic [ERR_W-1:0]  crc_err_cnt,
    output logic [ERR_W-1:0]  miss_cnt
);
    localparam int unsigned GAP_W  = $clog2(GAP_LIMIT + 1);
    localparam int unsigned MISS_W = $clog2(LOSS_LIMIT + 1);
    localparam logic [GAP_W-1:0]  GAP_END  = GAP_W'(GAP_LIMIT - 1);
    localparam logic [MISS_W-1:0] MISS_MAX = MISS_W'(LOSS_LIMIT);
    localparam logic [TIME_W-1:0] COMP     = TIME_W'(LAT_COMP);

    typedef struct packed {
        logic [TIME_W-1:0] tm;
        logic [TIME_W-1:0] hold;
        logic              upd;
        logic              dvld;
        logic [TIME_W-1:0] data;
        logic [1:0]        good;
        logic [MISS_W-1:0] miss_run;
        logic [GAP_W-1:0]  gap;
        logic              lock;
        logic [ERR_W-1:0]  crc_err;
        logic [ERR_W-1:0]  miss_err;
    } tk_t;

    tk_t q, d;
    logic [TIME_W-1:0] target;

    always_comb begin
        d = q;
        d.upd  = 1'b0;
        d.dvld = 1'b0;
        target = frm_pay + COMP;
        if (q.hold != '0) begin
            d.hold = q.hold - TIME_W'(1);
        end else begin
            d.tm = q.tm + TIME_W'(1);
        end
        d.gap = q.gap + GAP_W'(1);
        if (frm_done) begin
            d.gap = '0;
            if (frm_ok) begin
                d.miss_run = '0;
                if (frm_kind == KIND_TIME) begin
                    d.upd = 1'b1;
                    if (target > q.tm) begin
                        d.tm   = target;
                        d.hold = '0;
                    end else begin
                        d.tm   = q.tm;
                        d.hold = q.tm - target;
                    end
                    d.good = (q.good == 2'd2) ? 2'd2 : q.good + 2'd1;
                    if (d.good == 2'd2) d.lock = 1'b1;
                end else begin
                    d.dvld = 1'b1;
                    d.data = frm_pay;
                end
            end else begin
                if (q.crc_err != '1) d.crc_err = q.crc_err + ERR_W'(1);
                if (q.miss_run != MISS_MAX) d.miss_run = q.miss_run + MISS_W'(1);
                d.good = '0;
            end
        end else if (q.gap == GAP_END) begin
            d.gap = '0;
            if (q.miss_err != '1) d.miss_err = q.miss_err + ERR_W'(1);
            if (q.miss_run != MISS_MAX) d.miss_run = q.miss_run + MISS_W'(1);
            d.good = '0;
        end
        if (d.miss_run >= MISS_MAX) d.lock = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign local_time  = q.tm;
    assign time_upd    = q.upd;
    assign data_vld    = q.dvld;
    assign data_out    = q.data;
    assign locked      = q.lock;
    assign crc_err_cnt = q.crc_err;
    assign miss_cnt    = q.miss_err;

    AST_TIME_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        local_time >= $past(local_time)); // R6
    AST_FREE_RUN: assert property (@(posedge clk) disable iff (rst)
        (!frm_done && q.hold == '0) |=> local_time == $past(local_time) + TIME_W'(1)); // R7
    AST_BAD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (frm_done && !frm_ok) |=> (!time_upd && !data_vld)); // R8
    AST_CRC_COUNT: assert property (@(posedge clk) disable iff (rst)
        (frm_done && !frm_ok && crc_err_cnt != '1) |=> crc_err_cnt == $past(crc_err_cnt) + ERR_W'(1)); // R8
    AST_LOCK_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> time_upd); // R9
    AST_LOCK_FALL: assert property (@(posedge clk) disable iff (rst)
        (q.miss_run >= MISS_MAX) |-> !locked); // R10

endmodule

// File: rtl/tsr_rx.sv
module tsr_rx #(
    parameter int unsigned OVS        = 4,
    parameter int unsigned SYNC_W     = 32,
    parameter int unsigned TIME_W     = 32,
    parameter int unsigned LAT_COMP   = 24,
    parameter int unsigned GAP_LIMIT  = 1024,
    parameter int unsigned LOSS_LIMIT = 3,
    parameter int unsigned ERR_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_in,
    output logic [TIME_W-1:0] local_time,
    output logic              time_upd,
    output logic              data_vld,
    output logic [TIME_W-1:0] data_out,
    output logic              locked,
    output logic [ERR_W-1:0]  crc_err_cnt,
    output logic [ERR_W-1:0]  miss_cnt
);
    logic              bit_vld;
    logic              bit_val;
    logic              frm_done;
    logic              frm_ok;
    logic              frm_kind;
    logic [TIME_W-1:0] frm_pay;

    tsr_bit_recover #(.OVS(OVS)) u_bits (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_in),
        .bit_vld (bit_vld),
        .bit_val (bit_val)
    );

    tsr_framer #(.SYNC_W(SYNC_W), .PAY_W(TIME_W)) u_framer (
        .clk      (clk),
        .rst      (rst),
        .bit_vld  (bit_vld),
        .bit_val  (bit_val),
        .frm_done (frm_done),
        .frm_ok   (frm_ok),
        .frm_kind (frm_kind),
        .frm_pay  (frm_pay)
    );

    tsr_time_keeper #(
        .TIME_W     (TIME_W),
        .LAT_COMP   (LAT_COMP),
        .GAP_LIMIT  (GAP_LIMIT),
        .LOSS_LIMIT (LOSS_LIMIT),
        .ERR_W      (ERR_W)
    ) u_time (
        .clk         (clk),
        .rst         (rst),
        .frm_done    (frm_done),
        .frm_ok      (frm_ok),
        .frm_kind    (frm_kind),
        .frm_pay     (frm_pay),
        .local_time  (local_time),
        .time_upd    (time_upd),
        .data_vld    (data_vld),
        .data_out    (data_out),
        .locked      (locked),
        .crc_err_cnt (crc_err_cnt),
        .miss_cnt    (miss_cnt)
    );

    AST_UPD_XOR_DATA: assert property (@(posedge clk) disable iff (rst)
        !(time_upd && data_vld)); // R4

endmodule

// File: tb/test_tsr_rx.sv
module test_tsr_rx;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 24;
    localparam int GAP        = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_in = 1'b0;
    logic [31:0] local_time;
    logic        time_upd;
    logic        data_vld;
    logic [31:0] data_out;
    logic        locked;
    logic [7:0]  crc_err_cnt;
    logic [7:0]  miss_cnt;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tsr_rx i_tsr_rx (
        .clk         (clk),
        .rst         (rst),
        .line_in     (line_in),
        .local_time  (local_time),
        .time_upd    (time_upd),
        .data_vld    (data_vld),
        .data_out    (data_out),
        .locked      (locked),
        .crc_err_cnt (crc_err_cnt),
        .miss_cnt    (miss_cnt)
    );

    typedef struct packed {
        logic        is_time;
        logic [31:0] val;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    int   n_events = 0;
    int   mono_bad = 0;
    bit   finished = 1'b0;

    task automatic chk(input bit cond, input string req, input longint act, input longint expv);
        n_checks++;
        if (!cond) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [32:0] bits);
        logic [7:0] c = 8'h00;
        for (int i = 32; i >= 0; i--) begin
            logic top = c[7] ^ bits[i];
            c = c << 1;
            if (top) c = c ^ 8'h07;
        end
        return c;
    endfunction

    task automatic drive_bit(input logic b, input int w);
        line_in = b;
        repeat (w) @(negedge clk);
    endtask

    task automatic send_frame(input logic kind, input logic [31:0] pay,
                              input bit corrupt, input bit jitter);
        logic [40:0] body;
        logic [7:0]  c;
        c = ref_crc({kind, pay});
        if (corrupt) c = c ^ 8'h10;
        body = {kind, pay, c};
        if (!corrupt) exp_q.push_back('{is_time: kind, val: pay});
        for (int i = 0; i < 32; i++) drive_bit(1'b1, 4);
        drive_bit(1'b0, 4);
        for (int i = 40; i >= 0; i--) drive_bit(body[i], jitter ? ((i % 2 == 0) ? 5 : 3) : 4);
        drive_bit(1'b0, 4);
    endtask

    // monitor: scoreboard for output strobes and the hold behaviour
    initial begin : monitor
        logic [31:0] prev;
        logic [31:0] held;
        logic [31:0] refc;
        bit          frz;
        exp_t        e;
        prev = '0; held = '0; refc = '0; frz = 1'b0;
        forever begin
            @(negedge clk);
            if (rst) begin
                prev = local_time;
            end else begin
                if (local_time < prev) mono_bad++;
                if (time_upd || data_vld) begin
                    n_events++;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 unexpected strobe", {31'b0, time_upd}, 0);
                    end else begin
                        e = exp_q.pop_front();
                        if (time_upd) begin
                            chk(e.is_time == 1'b1, "R4 kind of strobe", 1, e.is_time);
                            refc = e.val + 32'(LAT);
                            if (refc > prev) begin
                                chk(local_time == refc, "R5 time load", local_time, refc);
                                frz = 1'b0;
                            end else begin
                                chk(local_time == prev, "R6 hold at update", local_time, prev);
                                held = prev;
                                frz  = 1'b1;
                            end
                        end else begin
                            chk(e.is_time == 1'b0, "R4 kind of strobe", 0, e.is_time);
                            chk(data_out == e.val, "R4 data payload", data_out, e.val);
                        end
                    end
                end else if (frz) begin
                    refc = refc + 32'd1;
                    chk(local_time == ((refc > held) ? refc : held), "R6 catch-up",
                        local_time, (refc > held) ? refc : held);
                    if (refc > held + 32'd3) frz = 1'b0;
                end
                prev = local_time;
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : driver
        logic [31:0] t0;
        int          ev0;
        repeat (5) @(negedge clk);
        chk(local_time == 0, "R11 time reset", local_time, 0);
        chk(locked == 1'b0, "R11 lock reset", locked, 0);
        chk(crc_err_cnt == 0 && miss_cnt == 0, "R11 counters reset", {crc_err_cnt, miss_cnt}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t0 = local_time;
        repeat (10) @(negedge clk);
        chk(local_time == t0 + 10, "R7 free run", local_time, t0 + 10);

        send_frame(1'b1, local_time + 32'd5000, 1'b0, 1'b0);
        repeat (16) @(negedge clk);
        chk(locked == 1'b0, "R9 one frame no lock", locked, 0);

        send_frame(1'b0, 32'hA5C3_0F1E, 1'b0, 1'b0);
        repeat (16) @(negedge clk);
        chk(locked == 1'b0, "R9 data does not lock", locked, 0);

        send_frame(1'b1, local_time + 32'd5000, 1'b0, 1'b0);
        repeat (16) @(negedge clk);
        chk(locked == 1'b1, "R9 lock after two", locked, 1);

        // R1 jittered bit cells
        send_frame(1'b0, 32'h0FF0_3C96, 1'b0, 1'b1);
        send_frame(1'b1, local_time + 32'd7000, 1'b0, 1'b1);
        repeat (16) @(negedge clk);
        chk(crc_err_cnt == 0, "R1 jitter tolerated", crc_err_cnt, 0);

        // R6 time behind local count
        send_frame(1'b1, local_time - 32'd200, 1'b0, 1'b0);
        repeat (700) @(negedge clk);

        // R3 / R8 corrupted data frame
        ev0 = n_events;
        send_frame(1'b0, 32'h1234_5678, 1'b1, 1'b0);
        repeat (16) @(negedge clk);
        chk(crc_err_cnt == 1, "R8 crc count", crc_err_cnt, 1);
        chk(n_events == ev0, "R3 bad frame discarded", n_events, ev0);
        chk(locked == 1'b1, "R10 single miss keeps lock", locked, 1);

        send_frame(1'b0, 32'h0000_0001, 1'b0, 1'b0);
        send_frame(1'b1, local_time + 32'd3000, 1'b1, 1'b0);
        send_frame(1'b1, local_time + 32'd3000, 1'b1, 1'b0);
        repeat (16) @(negedge clk);
        chk(locked == 1'b1, "R10 two misses keep lock", locked, 1);
        send_frame(1'b1, local_time + 32'd3000, 1'b1, 1'b0);
        repeat (16) @(negedge clk);
        chk(locked == 1'b0, "R10 lock lost on bad run", locked, 0);
        chk(crc_err_cnt == 4, "R8 crc count run", crc_err_cnt, 4);

        send_frame(1'b1, local_time + 32'd4000, 1'b0, 1'b0);
        send_frame(1'b1, local_time + 32'd4000, 1'b0, 1'b0);
        repeat (16) @(negedge clk);
        chk(locked == 1'b1, "R9 relock", locked, 1);

        // R10 silence
        repeat (3200) @(negedge clk);
        chk(miss_cnt == 3, "R10 timeout count", miss_cnt, 3);
        chk(locked == 1'b0, "R10 lock lost on silence", locked, 0);

        // R2 sync one bit short
        ev0 = n_events;
        for (int i = 0; i < 31; i++) drive_bit(1'b1, 4);
        drive_bit(1'b0, 4);
        for (int i = 0; i < 41; i++) drive_bit(i[0], 4);
        drive_bit(1'b0, 4);
        repeat (16) @(negedge clk);
        chk(n_events == ev0, "R2 short sync ignored", n_events, ev0);
        chk(crc_err_cnt == 4, "R2 short sync no frame", crc_err_cnt, 4);

        chk(exp_q.size() == 0, "R4 all frames delivered", exp_q.size(), 0);
        chk(mono_bad == 0, "R6 never backwards", mono_bad, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule